// File: doc/BRIEF.md
# S/PDIF Line Encoder with Preamble Rebuild

This block turns stored 56-bit frame records back into a continuous biphase-mark S/PDIF line signal. Upstream logic that reads the delay memory pushes records into a four-entry ring inside the block. Once per frame the encoder takes the oldest record, splits it into a left and a right 28-bit payload, puts the correct preamble in front of each half, and sends everything at two half-cells per bit. The preambles were removed before storage and are rebuilt here. The block-start preamble is placed using a modulo-192 frame counter.

The block runs on the clock recovered from the incoming stream, at 128 ticks per frame, so one clock equals one half-cell of output. If the ring is empty when a frame is due, the encoder sends an idle frame instead, so the line never stops. An idle frame has zero audio, user and channel-status bits, a valid flag that marks the data as not audio, and correct parity. A record can carry a block-start mark. When that record goes out, the frame counter is forced back to zero, so the output block framing follows the input framing.

Top module: `spdif_bmc_tx`

## Requirements
- R1: A frame lasts exactly 128 clocks. `frame_req` is high for exactly one clock per frame: the clock whose rising edge emits half-cell 127 of the current frame and loads the next record.
- R2: Every data bit cell starts with a level change from the previous half-cell. A bit of 1 adds a second change between its two half-cells; a bit of 0 does not.
- R3: Record bits [27:0] form the left subframe payload and bits [55:28] the right one. Within a subframe, payload bit 0 is sent first and bit 27 last. Bits 0..23 are audio (LSB first), bit 24 is valid, 25 user, 26 channel status and 27 parity.
- R4: A subframe starts with 8 preamble half-cells, emitted left to right. Measured from a previous level of 0, the patterns are: block start 11101000, ordinary left 11100010, right 11100100. When the previous level is 1, the pattern is inverted, so the first half-cell is always opposite to the previous level.
- R5: Frames are counted modulo 192. The left subframe of frame index 0 uses the block-start preamble; every other left subframe uses the ordinary left preamble. The first frame after reset has index 0.
- R6: A record written with `wr_blk` high resets the frame index to 0 when that record is sent, so its left subframe carries the block-start preamble.
- R7: The ring holds four records. `ring_full` is high one clock after the fourth record is held. A write while the ring is full is dropped and never appears on the line.
- R8: Records are sent in write order, one per frame. A write must land at least one rising edge before the frame-boundary edge to be used for the next frame.
- R9: When the ring is empty at a frame boundary, the frame sent has both payloads equal to 0x9000000 (valid=1, parity=1, all else 0). The frame index still advances and the preambles follow R4 and R5.
- R10: While reset is held, `line_out`, `ring_full` and `frame_req` are 0. Reset removal passes through a two-stage synchroniser, and the first frame after reset is an idle frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered clock, 128 ticks per frame |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push one record into the ring |
| wr_rec | input | 56 | Frame record: left payload [27:0], right payload [55:28] |
| wr_blk | input | 1 | Pushed record is frame 0 of a block |
| ring_full | output | 1 | Ring holds four records |
| frame_req | output | 1 | One-clock pulse at each frame boundary, asking for the next record |
| line_out | output | 1 | Biphase-mark S/PDIF line level |

## Verification
Counting from the third rising edge after reset is released, half-cell h of frame f appears on `line_out` just after edge 128f+h+1. The bench therefore samples on the falling edge and treats sample number i as half-cell i mod 128 of frame i/128. In the same sample numbering, `frame_req` is expected high exactly at samples 126 mod 128. Writes are driven on a falling edge and take effect at the next rising edge, so the bench issues them well away from the boundary edge and updates its own queue model at that point. `ring_full` is checked on the sample after each write in a burst, where the fourth write first shows the flag.

// File: rtl/spdif_enc_pkg.sv
package spdif_enc_pkg;

  localparam int unsigned SUBF_BITS  = 28;
  localparam int unsigned REC_BITS   = 2 * SUBF_BITS;
  localparam int unsigned VALID_POS  = 24;
  localparam int unsigned PARITY_POS = 27;

  typedef logic [REC_BITS-1:0] frame_rec_t;

  typedef enum logic [1:0] {
    PRE_BLOCK = 2'd0,
    PRE_LEFT  = 2'd1,
    PRE_RIGHT = 2'd2
  } pre_kind_e;

  // Half-cell pattern for a previous line level of 0, first half-cell at bit 7.
  function automatic logic [7:0] pre_pattern(input pre_kind_e kind);
    case (kind)
      PRE_BLOCK: return 8'b1110_1000;
      PRE_LEFT:  return 8'b1110_0010;
      default:   return 8'b1110_0100;
    endcase
  endfunction

  // Filler frame: no audio, valid flag says "not audio", parity even.
  function automatic frame_rec_t idle_record();
    logic [SUBF_BITS-1:0] half;
    half             = '0;
    half[VALID_POS]  = 1'b1;
    half[PARITY_POS] = 1'b1;
    return {half, half};
  endfunction

endpackage

// File: rtl/spdif_frame_ring.sv
module spdif_frame_ring #(
  parameter  int unsigned DEPTH = 4,
  parameter  int unsigned WIDTH = 57,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    count
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_wr, do_rd;

  always_comb begin
    do_wr    = wr_en && (cnt_q != CW'(DEPTH));
    do_rd    = rd_en && (cnt_q != '0);
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_wr) begin
      wr_ptr_d = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    end
    if (do_rd) begin
      rd_ptr_d = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({do_wr, do_rd})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage carries no reset; entries are only read after being written.
  always_ff @(posedge clk) begin
    if (do_wr) begin
      mem[wr_ptr_q] <= wr_data;
    end
  end

  assign rd_data = mem[rd_ptr_q];
  assign count   = cnt_q;

endmodule

// File: rtl/spdif_bmc_coder.sv
module spdif_bmc_coder
  import spdif_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] hc,
  input  frame_rec_t rec,
  input  logic       block_first,
  output logic       line
);

  logic                 line_q, line_d;
  logic                 inv_q, inv_d;
  logic                 sub_sel;
  logic [4:0]           slot;
  logic [4:0]           bit_idx;
  logic [2:0]           pre_idx;
  logic [SUBF_BITS-1:0] half_pay;
  logic [7:0]           pat;
  pre_kind_e            kind;
  logic                 cur_bit;

  always_comb begin
    sub_sel  = hc[6];
    slot     = hc[5:1];
    pre_idx  = hc[2:0];
    bit_idx  = slot - 5'd4;
    half_pay = sub_sel ? rec[REC_BITS-1:SUBF_BITS] : rec[SUBF_BITS-1:0];
    cur_bit  = half_pay[bit_idx];
    if (sub_sel) begin
      kind = PRE_RIGHT;
    end else if (block_first) begin
      kind = PRE_BLOCK;
    end else begin
      kind = PRE_LEFT;
    end
    pat    = pre_pattern(kind);
    inv_d  = inv_q;
    line_d = line_q;
    if (slot < 5'd4) begin
      // polarity is fixed at the first preamble half-cell
      if (pre_idx == 3'd0) begin
        inv_d = line_q;
      end
      line_d = pat[3'd7 - pre_idx] ^ inv_d;
    end else if (!hc[0]) begin
      line_d = ~line_q;
    end else begin
      line_d = cur_bit ? ~line_q : line_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      inv_q  <= 1'b0;
    end else begin
      line_q <= line_d;
      inv_q  <= inv_d;
    end
  end

  assign line = line_q;

endmodule

// File: rtl/spdif_bmc_tx.sv
module spdif_bmc_tx
  import spdif_enc_pkg::*;
#(
  parameter int unsigned RING_DEPTH       = 4,
  parameter int unsigned FRAMES_PER_BLOCK = 192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REC_BITS-1:0] wr_rec,
  input  logic                wr_blk,
  output logic                ring_full,
  output logic                frame_req,
  output logic                line_out
);

  localparam int unsigned HC_W   = 7;
  localparam int unsigned BLK_W  = $clog2(FRAMES_PER_BLOCK);
  localparam int unsigned CNT_W  = $clog2(RING_DEPTH + 1);
  localparam int unsigned ENT_W  = REC_BITS + 1;

  logic             rst_s1_q, rst_core_n;
  logic [HC_W-1:0]  hc_q, hc_d;
  frame_rec_t       rec_q, rec_d;
  logic [BLK_W-1:0] blk_q, blk_d, blk_inc;
  logic             load, ring_empty;
  logic [ENT_W-1:0] ring_rd;
  logic [CNT_W-1:0] ring_cnt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_core_n <= rst_s1_q;
    end
  end

  spdif_frame_ring #(
    .DEPTH (RING_DEPTH),
    .WIDTH (ENT_W)
  ) u_ring (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .wr_data ({wr_blk, wr_rec}),
    .rd_en   (load),
    .rd_data (ring_rd),
    .count   (ring_cnt)
  );

  assign ring_full  = (ring_cnt == CNT_W'(RING_DEPTH));
  assign ring_empty = (ring_cnt == '0);
  assign frame_req  = (hc_q == {HC_W{1'b1}});
  assign load       = frame_req;

  always_comb begin
    hc_d    = hc_q + 1'b1;
    blk_inc = (blk_q == BLK_W'(FRAMES_PER_BLOCK - 1)) ? '0 : blk_q + 1'b1;
    if (ring_empty) begin
      rec_d = idle_record();
      blk_d = blk_inc;
    end else begin
      rec_d = ring_rd[REC_BITS-1:0];
      blk_d = ring_rd[REC_BITS] ? '0 : blk_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      hc_q  <= '0;
      rec_q <= idle_record();
      blk_q <= '0;
    end else begin
      hc_q <= hc_d;
      if (load) begin
        rec_q <= rec_d;
        blk_q <= blk_d;
      end
    end
  end

  spdif_bmc_coder u_coder (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .hc          (hc_q),
    .rec         (rec_q),
    .block_first (blk_q == '0),
    .line        (line_out)
  );

endmodule

// File: rtl/spdif_bmc_tx_chk.sv
module spdif_bmc_tx_chk #(
  parameter  int unsigned DEPTH = 4,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [6:0]    hc,
  input logic          line,
  input logic          frame_req,
  input logic          wr_en,
  input logic          ring_full,
  input logic [CW-1:0] ring_cnt
);

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_req |=> !frame_req); // R1

  AST_CELL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (hc[5:1] >= 5'd4 && !hc[0]) |=> (line != $past(line))); // R2

  AST_PRE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (hc[5:0] == 6'd0) |=> (line != $past(line))); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ring_cnt <= CW'(DEPTH)); // R7

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_full && wr_en && !frame_req) |=> (ring_full && $stable(ring_cnt))); // R7

endmodule

bind spdif_bmc_tx spdif_bmc_tx_chk #(.DEPTH(RING_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .hc        (hc_q),
  .line      (line_out),
  .frame_req (frame_req),
  .wr_en     (wr_en),
  .ring_full (ring_full),
  .ring_cnt  (ring_cnt)
);

// File: tb/spdif_bmc_tx_tb_top.sv
`timescale 1ns/1ps
module spdif_bmc_tx_tb_top;

  localparam int NFRAMES = 218;
  localparam int RESYNC_F = 200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [55:0] wr_rec;
  logic        wr_blk;
  logic        ring_full, frame_req, line_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  spdif_bmc_tx dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_rec    (wr_rec),
    .wr_blk    (wr_blk),
    .ring_full (ring_full),
    .frame_req (frame_req),
    .line_out  (line_out)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [55:0] rec_of(input int n);
    case (n % 4)
      0: return 56'h0;
      1: return {56{1'b1}};
      2: return 56'hA5_5AAA_5555_AAAA;
      default: return {n * 32'h9E37_79B1, n[23:0] * 24'h5B_D1E9};
    endcase
  endfunction

  function automatic logic [127:0] gen_wave(input logic [55:0] rec, input bit blk0, input logic last);
    logic [127:0] w;
    logic [7:0]   pat;
    logic         lv, inv;
    lv = last;
    w  = '0;
    for (int s = 0; s < 2; s++) begin
      if (s == 1)  pat = 8'b1110_0100;
      else if (blk0) pat = 8'b1110_1000;
      else pat = 8'b1110_0010;
      inv = lv;
      for (int p = 0; p < 8; p++) begin
        lv = pat[7-p] ^ inv;
        w[s*64+p] = lv;
      end
      for (int j = 0; j < 28; j++) begin
        lv = ~lv;
        w[s*64+8+2*j] = lv;
        if (rec[s*28+j]) lv = ~lv;
        w[s*64+9+2*j] = lv;
      end
    end
    return w;
  endfunction

  logic [56:0] q [8];
  int q_head = 0, q_tail = 0, q_n = 0;

  task automatic push_rec(input logic [55:0] r, input logic b);
    wr_en  = 1'b1;
    wr_rec = r;
    wr_blk = b;
    if (q_n < 4) begin
      q[q_tail] = {b, r};
      q_tail = (q_tail + 1) % 8;
      q_n++;
    end
  endtask

  initial begin
    logic [55:0]  cur;
    logic [55:0]  idle;
    logic [127:0] exp_w, rx;
    logic         last, prev;
    int           blkidx, req_bad;
    string        tag;
    idle   = {28'h900_0000, 28'h900_0000};
    rst_n  = 1'b0;
    wr_en  = 1'b0;
    wr_rec = '0;
    wr_blk = 1'b0;
    last   = 1'b0;
    blkidx = 0;
    req_bad = 0;
    cur    = idle;
    exp_w  = '0;
    rx     = '0;
    tag    = "";
    repeat (4) @(negedge clk);
    // R10: quiet outputs under reset
    check(line_out == 1'b0 && ring_full == 1'b0 && frame_req == 1'b0, "R10 reset outputs",
          {125'b0, line_out, ring_full, frame_req}, 128'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NFRAMES * 128; i++) begin
      int hcx, f;
      @(negedge clk);
      wr_en = 1'b0;
      wr_blk = 1'b0;
      hcx = i % 128;
      f   = i / 128;
      if (hcx == 0) begin
        req_bad = 0;
        if (f == 0) begin
          cur = idle; blkidx = 0; tag = "R10 first frame idle";
        end else if (q_n > 0) begin
          cur = q[q_head][55:0];
          if (q[q_head][56]) begin
            blkidx = 0; tag = "R6 resync frame";
          end else begin
            blkidx = (blkidx == 191) ? 0 : blkidx + 1;
            tag = (blkidx == 0) ? "R5 block wrap frame" : "R8 data frame";
          end
          q_head = (q_head + 1) % 8;
          q_n--;
        end else begin
          cur = idle;
          blkidx = (blkidx == 191) ? 0 : blkidx + 1;
          tag = (blkidx == 0) ? "R5 idle block wrap" : "R9 idle frame";
        end
        exp_w = gen_wave(cur, blkidx == 0, last);
        prev  = last;
        last  = exp_w[127];
      end
      rx[hcx] = line_out;
      if (frame_req != (hcx == 126)) req_bad++;
      if (hcx == 127) begin
        logic [55:0] dec;
        int edge_bad;
        check(rx == exp_w, $sformatf("%s f=%0d", tag, f), rx, exp_w);
        check({rx[71:64], rx[7:0]} == {exp_w[71:64], exp_w[7:0]},
              $sformatf("R4 preambles f=%0d", f),
              {112'b0, rx[71:64], rx[7:0]}, {112'b0, exp_w[71:64], exp_w[7:0]});
        edge_bad = 0;
        if (rx[0] == prev) edge_bad++;
        for (int s = 0; s < 2; s++) begin
          for (int j = 0; j < 28; j++) begin
            dec[s*28+j] = rx[s*64+8+2*j] ^ rx[s*64+9+2*j];
            if (rx[s*64+8+2*j] == rx[s*64+7+2*j]) edge_bad++;
          end
        end
        check(dec == cur, $sformatf("R3 decoded payload f=%0d", f), {72'b0, dec}, {72'b0, cur});
        check(edge_bad == 0, $sformatf("R2 cell edges f=%0d", f), 128'(edge_bad), 128'h0);
        check(req_bad == 0, $sformatf("R1 frame_req pulse f=%0d", f), 128'(req_bad), 128'h0);
      end
      // steady feed, one record per frame; resync mark on one of them
      if (f >= 2 && f <= 205 && hcx == 50) begin
        push_rec(rec_of(f), f == RESYNC_F);
      end
      // R7 burst of five writes into an empty ring
      if (f == 210 && hcx >= 20 && hcx <= 24) begin
        if (hcx == 23) check(ring_full == 1'b0, "R7 three held", {127'b0, ring_full}, 128'h0);
        if (hcx == 24) check(ring_full == 1'b1, "R7 four held", {127'b0, ring_full}, 128'h1);
        push_rec(rec_of(1000 + hcx), 1'b0);
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule